// File: doc/BRIEF.md
# Programmable Multi-Mode Timer Channel

A single timer channel for a small multi-timer peripheral. Software writes a 32-bit match value and a control word through a simple write port. A write of the control word can start, stop or clear the channel, and it also sets the channel's persistent settings. The channel then counts down from the match value. It steps on every system clock, on an external 1 µs tick or on an external 256 µs tick. When the count runs out, the channel raises a timeout flag.

In one-shot mode the channel stops at the timeout. In periodic mode it reloads from the match value and keeps running. The timeout flag stays set until software clears it. The interrupt output is the flag gated by an enable bit. The count can be read back either as the remaining count or as elapsed units counted up from zero. The tick pulses come from a timebase outside this block.

Top module: `tmr_channel`

## Requirements
- R1: After reset the match readback, control readback and count readback are 0, and `running`, `irqPending` and `irq` are 0.
- R2: A write with `matchWe` stores `wrData` as the match value, and `matchRdata` returns it from the next cycle.
- R3: A write with `ctrlWe` stores the fields held in the control word, and `ctrlRdata` returns them from the next cycle. The stored fields are: interrupt enable at bit 2, timebase at bits 4:3, periodic at bit 5 and up-view at bit 7. The strobe bits 0, 1 and 6 and every other bit read as 0.
- R4: Bit 0 of a control write starts the channel. It loads the count with the current match value and sets `running`, unless the match value is 0, in which case `running` stays 0. A start also restarts a channel that is already running.
- R5: While running, the count drops by one per step. The timebase field sets what counts as a step: 0 means every clock, 1 means each cycle with `usTick` high, and 2 means each cycle with `tick256` high. With value 3 the count holds.
- R6: A step taken when the count is 1 is a timeout. It sets `irqPending`. In one-shot mode (bit 5 = 0) it also clears `running` and leaves the count at 0.
- R7: In periodic mode (bit 5 = 1), a timeout reloads the count from the current match value and the channel keeps running.
- R8: Bit 6 of a control write clears `running` and freezes the count. When bits 0 and 6 are written together, the stop takes priority.
- R9: `irq` equals `irqPending` AND the enable bit. `irqPending` is set by a timeout even while the interrupt is disabled.
- R10: Bit 1 of a control write clears `irqPending`. If a timeout occurs in the same cycle, `irqPending` stays set.
- R11: With up-view set (bit 7 = 1), `countRdata` reads as the value loaded at the last start or reload minus the remaining count. With up-view clear, `countRdata` reads the remaining count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| matchWe | input | 1 | Write strobe for the match value |
| ctrlWe | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data shared by both strobes |
| usTick | input | 1 | One-cycle pulse every microsecond |
| tick256 | input | 1 | One-cycle pulse every 256 microseconds |
| matchRdata | output | 32 | Stored match value |
| ctrlRdata | output | 32 | Stored control fields, strobe bits read 0 |
| countRdata | output | 32 | Remaining count or elapsed count (up-view) |
| running | output | 1 | Channel active |
| irqPending | output | 1 | Timeout flag |
| irq | output | 1 | Timeout flag gated by the enable |

## Verification
Every result is registered once. A write, a tick or a timeout sampled at one rising edge shows up on the readbacks, `running` and `irqPending` just after that same edge. `irq` then follows without any further delay. The bench drives inputs on falling edges and updates its behavioural model at each rising edge from the same inputs. It compares every output 3 ns after each rising edge, which is the cycle in which the result is due. The clear-against-timeout race is lined up by watching the model until it predicts a timeout on the next edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    TB_SYSCLK = 2'd0,
    TB_US     = 2'd1,
    TB_256US  = 2'd2,
    TB_HOLD   = 2'd3
  } timebase_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic step;
    logic periodic;
  } dp_cmd_t;

  localparam int CB_START    = 0;
  localparam int CB_CLEAR    = 1;
  localparam int CB_IRQ_EN   = 2;
  localparam int CB_TB_LO    = 3;
  localparam int CB_TB_HI    = 4;
  localparam int CB_PERIODIC = 5;
  localparam int CB_STOP     = 6;
  localparam int CB_UP_VIEW  = 7;

endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              matchWe,
  input  logic              ctrlWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  input  logic              tick256,
  input  logic              active,
  input  logic              timeout,
  output logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] ctrlRdata,
  output dp_cmd_t           cmd,
  output logic              upView,
  output logic              irqPending,
  output logic              irq
);

  logic      irqEn;
  logic      periodic;
  timebase_e timebase;
  logic      startStb;
  logic      stopStb;
  logic      clearStb;
  logic      stepSel;

  assign startStb = ctrlWe && wrData[CB_START];
  assign stopStb  = ctrlWe && wrData[CB_STOP];
  assign clearStb = ctrlWe && wrData[CB_CLEAR];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVal <= '0;
    end else if (matchWe) begin
      matchVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      periodic <= 1'b0;
      upView   <= 1'b0;
      timebase <= TB_SYSCLK;
    end else if (ctrlWe) begin
      irqEn    <= wrData[CB_IRQ_EN];
      periodic <= wrData[CB_PERIODIC];
      upView   <= wrData[CB_UP_VIEW];
      timebase <= timebase_e'(wrData[CB_TB_HI:CB_TB_LO]);
    end
  end

  always_comb begin
    case (timebase)
      TB_SYSCLK: stepSel = 1'b1;
      TB_US:     stepSel = usTick;
      TB_256US:  stepSel = tick256;
      default:   stepSel = 1'b0;
    endcase
  end

  always_comb begin
    cmd.start    = startStb;
    cmd.stop     = stopStb;
    cmd.step     = active && stepSel;
    cmd.periodic = periodic;
  end

  always_comb begin
    ctrlRdata                    = '0;
    ctrlRdata[CB_IRQ_EN]         = irqEn;
    ctrlRdata[CB_TB_HI:CB_TB_LO] = timebase;
    ctrlRdata[CB_PERIODIC]       = periodic;
    ctrlRdata[CB_UP_VIEW]        = upView;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
    end else if (timeout) begin
      irqPending <= 1'b1;
    end else if (clearStb) begin
      irqPending <= 1'b0;
    end
  end

  assign irq = irqPending && irqEn;

  assert_timeout_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> irqPending);

  assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clearStb && !timeout) |=> !irqPending);

  assert_hold_no_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timebase == TB_HOLD) |-> !cmd.step);

  assert_masked_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !wrData[CB_IRQ_EN]) |=> !irq);

endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_chan_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_cmd_t          cmd,
  input  logic [CNT_W-1:0] matchVal,
  input  logic             upView,
  output logic [CNT_W-1:0] countView,
  output logic             active,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countDown;
  logic [CNT_W-1:0] loadVal;

  assign timeout = cmd.step && (countDown <= ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countDown <= '0;
      loadVal   <= '0;
      active    <= 1'b0;
    end else if (cmd.stop) begin
      active <= 1'b0;
    end else if (cmd.start) begin
      countDown <= matchVal;
      loadVal   <= matchVal;
      active    <= (matchVal != '0);
    end else if (timeout) begin
      if (cmd.periodic) begin
        countDown <= matchVal;
        loadVal   <= matchVal;
      end else begin
        countDown <= '0;
        active    <= 1'b0;
      end
    end else if (cmd.step) begin
      countDown <= countDown - ONE;
    end
  end

  assign countView = upView ? (loadVal - countDown) : countDown;

  assert_start_loads_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !cmd.stop && matchVal != '0) |=> (active && countDown == $past(matchVal)));

  assert_oneshot_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !cmd.periodic && !cmd.stop && !cmd.start) |=> (!active && countDown == '0));

  assert_periodic_runs_R7: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && cmd.periodic && !cmd.stop && !cmd.start) |=> active);

  assert_stop_halts_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stop |=> (!active && $stable(countDown)));

  assert_no_step_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.start) |=> $stable(countDown));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_chan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              matchWe,
  input  logic              ctrlWe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              usTick,
  input  logic              tick256,
  output logic [DATA_W-1:0] matchRdata,
  output logic [DATA_W-1:0] ctrlRdata,
  output logic [DATA_W-1:0] countRdata,
  output logic              running,
  output logic              irqPending,
  output logic              irq
);

  dp_cmd_t     cmd;
  logic        timeout;
  logic        upView;

  tmr_chan_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .matchWe   (matchWe),
    .ctrlWe    (ctrlWe),
    .wrData    (wrData),
    .usTick    (usTick),
    .tick256   (tick256),
    .active    (running),
    .timeout   (timeout),
    .matchVal  (matchRdata),
    .ctrlRdata (ctrlRdata),
    .cmd       (cmd),
    .upView    (upView),
    .irqPending(irqPending),
    .irq       (irq)
  );

  tmr_chan_dp #(.CNT_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .matchVal (matchRdata),
    .upView   (upView),
    .countView(countRdata),
    .active   (running),
    .timeout  (timeout)
  );

endmodule

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        matchWe = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [31:0] wrData = '0;
  logic        usTick = 1'b0;
  logic        tick256 = 1'b0;
  logic [31:0] matchRdata, ctrlRdata, countRdata;
  logic        running, irqPending, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rstN(rstN), .matchWe(matchWe), .ctrlWe(ctrlWe), .wrData(wrData),
    .usTick(usTick), .tick256(tick256), .matchRdata(matchRdata), .ctrlRdata(ctrlRdata),
    .countRdata(countRdata), .running(running), .irqPending(irqPending), .irq(irq)
  );

  // tick generators: usTick every 3 clocks, tick256 every 7 clocks
  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt <= tickCnt + 1;
    usTick  <= ((tickCnt % 3) == 0);
    tick256 <= ((tickCnt % 7) == 0);
  end

  // behavioural reference model
  int unsigned mMatch, mRemain, mLoad;
  int unsigned mType;
  bit mEn, mPer, mUp, mActive, mStat;

  always @(posedge clk) begin
    bit step, tmo, st, cl, sp;
    if (!rstN) begin
      mMatch = 0; mRemain = 0; mLoad = 0; mType = 0;
      mEn = 0; mPer = 0; mUp = 0; mActive = 0; mStat = 0;
    end else begin
      step = mActive && ((mType == 0) || (mType == 1 && usTick) || (mType == 2 && tick256));
      tmo  = step && (mRemain <= 1);
      st = ctrlWe && wrData[0];
      cl = ctrlWe && wrData[1];
      sp = ctrlWe && wrData[6];
      if (sp) mActive = 0;
      else if (st) begin
        mRemain = mMatch; mLoad = mMatch; mActive = (mMatch != 0);
      end else if (tmo) begin
        if (mPer) begin mRemain = mMatch; mLoad = mMatch; end
        else begin mRemain = 0; mActive = 0; end
      end else if (step) mRemain = mRemain - 1;
      if (tmo) mStat = 1; else if (cl) mStat = 0;
      if (ctrlWe) begin
        mEn = wrData[2]; mType = wrData[4:3]; mPer = wrData[5]; mUp = wrData[7];
      end
      if (matchWe) mMatch = wrData;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 3 ns after each rising edge
  always @(posedge clk) begin
    #3;
    if (rstN && !finished) begin
      check("R2 match", matchRdata, mMatch);
      check("R3 ctrl", ctrlRdata, (32'(mUp) << 7) | (32'(mPer) << 5) | (mType << 3) | (32'(mEn) << 2));
      check(mUp ? "R11 count" : "R5 count", countRdata, mUp ? (mLoad - mRemain) : mRemain);
      check("R4 running", {31'b0, running}, {31'b0, mActive});
      check("R6 pending", {31'b0, irqPending}, {31'b0, mStat});
      check("R9 irq", {31'b0, irq}, {31'b0, mStat & mEn});
    end
  end

  task automatic wrMatch(logic [31:0] v);
    @(negedge clk); matchWe = 1; wrData = v;
    @(negedge clk); matchWe = 0; wrData = 0;
  endtask

  task automatic wrCtrl(logic [31:0] v);
    @(negedge clk); ctrlWe = 1; wrData = v;
    @(negedge clk); ctrlWe = 0; wrData = 0;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int guard;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 match", matchRdata, 0);
    check("R1 ctrl", ctrlRdata, 0);
    check("R1 count", countRdata, 0);
    check("R1 flags", {29'b0, running, irqPending, irq}, 0);
    rstN = 1;
    waitCycles(2);

    wrMatch(32'd5);
    check("R2 readback", matchRdata, 32'd5);

    // all bits: stop beats start, strobes read 0
    wrCtrl(32'hFFFF_FFFF);
    check("R3 strobes read zero", ctrlRdata, 32'h0000_00BC);
    check("R8 stop wins over start", {31'b0, running}, 0);

    // one-shot, system clock, enabled
    wrCtrl(32'h0000_0005);
    check("R4 start loads", countRdata, 32'd5);
    check("R4 running", {31'b0, running}, 1);
    waitCycles(5);
    check("R6 oneshot stopped", {31'b0, running}, 0);
    check("R6 count zero", countRdata, 0);
    check("R9 irq enabled", {31'b0, irq}, 1);
    wrCtrl(32'h0000_0002);
    check("R10 cleared", {31'b0, irqPending}, 0);

    // disabled interrupt still sets pending
    wrMatch(32'd3);
    wrCtrl(32'h0000_0001);
    waitCycles(4);
    check("R9 pending while masked", {30'b0, irqPending, irq}, 32'b10);
    wrCtrl(32'h0000_0002);

    // periodic, 1 us tick, up view
    wrMatch(32'd4);
    wrCtrl(32'h0000_00AD);
    waitCycles(40);
    check("R7 periodic still running", {31'b0, running}, 1);
    check("R7 pending", {31'b0, irqPending}, 1);

    // type 3 holds, then stop freezes
    wrCtrl(32'h0000_0018 | 32'h2);
    waitCycles(6);
    check("R5 hold", {31'b0, running}, 1);
    wrCtrl(32'h0000_0040);
    check("R8 stopped", {31'b0, running}, 0);
    waitCycles(5);

    // 256 us tick, one-shot, down view
    wrMatch(32'd2);
    wrCtrl(32'h0000_0015);
    waitCycles(30);
    check("R5 tick256 done", {31'b0, running}, 0);

    // clear colliding with timeout: periodic system clock, match 3
    wrMatch(32'd3);
    wrCtrl(32'h0000_0027);
    guard = 0;
    @(negedge clk);
    while (!(mActive && mRemain == 1) && guard < 20) begin
      @(negedge clk); guard++;
    end
    ctrlWe = 1; wrData = 32'h0000_0026;
    @(negedge clk); ctrlWe = 0; wrData = 0;
    check("R10 timeout beats clear", {31'b0, irqPending}, 1);
    // clear with no timeout
    ctrlWe = 1; wrData = 32'h0000_0026;
    @(negedge clk); ctrlWe = 0; wrData = 0;
    check("R10 plain clear", {31'b0, irqPending}, 0);

    // start with match 0 stays idle
    wrCtrl(32'h0000_0040);
    wrMatch(32'd0);
    wrCtrl(32'h0000_0001);
    check("R4 zero match idle", {31'b0, running}, 0);
    waitCycles(3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule